// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked static memory with a four-beat burst engine, meant to sit behind a processor or a memory controller on a wide data bus. A burst opens when either of two active-low address strobes is sampled low. One strobe belongs to the processor and one to the controller. The external address is loaded and the first beat is accessed. Later beats come from an internal two-bit counter that moves only on edges where the active-low advance input is low. The `ord_lin` pin picks the beat order: high gives linear order and low gives interleaved order.

Each word is split into byte lanes of nine bits: eight data bits and one parity bit. Writes use controls registered at the sampling edge and finish on the following edge without any further handshake. A lane is written when the byte-write qualifier and that lane's enable are both low. The write-all input writes every lane. Read data passes through two registers on its way out. The output-drive flag has its own pipeline, so after a deselect the data stays driven for one extra cycle. The output-enable pin gates that flag with no register in between.

Top module: `sbsram_top`

## Requirements
- R1: The chip is selected when `cs_n`=0, `cs`=1 and `cs2_n`=0. With `strobe_ctl_n` low and the chip unselected, the burst ends and no access takes place until a new start. With `strobe_cpu_n` low, `strobe_ctl_n` high and the chip unselected, the processor strobe is ignored and the edge acts as a plain continuation.
- R2: On an edge where the chip is selected and either strobe is low, a burst starts at `addr` and that address is accessed as the first beat.
- R3: Read data for an access sampled at edge k appears on `dout` after edge k+2, with `dout_drv` high when `oe_n` is low.
- R4: During a burst, the beat counter advances only on edges where `adv_n` is low. With `adv_n` high, the same address is accessed again.
- R5: With `ord_lin`=1, beat n accesses low address bits (base+n) mod 4. The upper address bits stay fixed.
- R6: With `ord_lin`=0, beat n accesses low address bits base XOR n. The upper address bits stay fixed.
- R7: An access is a write when `bwe_n`=0 and at least one bit of `lane_we_n` is 0. Lane i is `din[9i+8:9i]`, with parity at bit 9i+8. Only lanes whose enable bit is 0 are written, and the other lanes keep their old content. With `bwe_n`=1 the lane enables have no effect and the access is a read.
- R8: With `wr_all_n`=0, every lane of the accessed word is written, whatever the values of `bwe_n` and `lane_we_n`.
- R9: Address, write controls and write data are all captured at one edge. A read of the same word sampled on the very next edge returns the newly written data.
- R10: When a read's output cycle is followed by the output slot of a deselect, `dout_drv` stays high for one more cycle with `dout` unchanged, then goes low. When a write follows a read, `dout_drv` drops with no extra cycle.
- R11: `oe_n`=1 forces `dout_drv` low within the same cycle, with no clock edge in between.
- R12: After reset no burst is active. Continuation edges access nothing, and `dout_drv` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | External word address |
| strobe_cpu_n | input | 1 | Processor burst-start strobe, active low |
| strobe_ctl_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip enable, active low |
| cs | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Second chip enable, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| ord_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, unregistered |
| din | input | 9*LANES | Write data with one parity bit per lane |
| dout | output | 9*LANES | Registered read data |
| dout_drv | output | 1 | Tri-state drive enable for the data bus |

## Verification
The bench targets the corners where a plausible design goes wrong.

- **Counter wrap.** Bursts start at every low-address offset in both orders. A design that lets the counter carry into the upper bits, or that uses the linear order in place of XOR, returns a neighbour's data.
- **Processor strobe while deselected.** The bench issues this strobe in the middle of a burst with a different address. A design that honours it jumps to the new address instead of taking the next beat.
- **Output-drive tail.** A read followed by a deselect is compared with a read followed by a write. A design without the extra enable stage drops `dout_drv` one cycle early, and one that always stretches it holds the bus during the write.
- **Lane writes.** Partial lane masks, the write-all override and a read right after a write catch lane mix-ups and missing data registers.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
   localparam int LANE_W  = 9;
   localparam int BURST_W = 2;

   function automatic logic [BURST_W-1:0] beat_low(input logic [BURST_W-1:0] base,
                                                   input logic [BURST_W-1:0] n,
                                                   input logic               lin);
      return lin ? base + n : base ^ n;
   endfunction
endpackage

// File: rtl/sbsram_lane_mask.sv
module sbsram_lane_mask #(
   parameter int LANES = 4
) (
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic             wr_all_n,
   output logic [LANES-1:0] mask
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = !wr_all_n || (!bwe_n && !lane_we_n[i]);
   end
endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              sel,
   input  logic              ord_lin,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              wr_all_n,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_rd,
   output logic              acc_wr,
   output logic              acc_ds,
   output logic [LANES-1:0]  acc_mask
);
   logic              active, nxt_active, lin_q;
   logic [ADDR_W-1:0] base, nxt_base;
   logic [BURST_W-1:0] cnt, nxt_cnt;
   logic              start, desel, is_wr;
   logic [LANES-1:0]  mask_c;

   sbsram_lane_mask #(.LANES(LANES)) u_mask (
      .bwe_n(bwe_n), .lane_we_n(lane_we_n), .wr_all_n(wr_all_n), .mask(mask_c)
   );

   always_comb begin
      start      = sel && (!strobe_cpu_n || !strobe_ctl_n);
      desel      = !strobe_ctl_n && !sel;
      is_wr      = |mask_c;
      nxt_base   = start ? addr : base;
      nxt_cnt    = start ? '0 : ((active && !adv_n) ? cnt + 1'b1 : cnt);
      nxt_active = desel ? 1'b0 : (start ? 1'b1 : active);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         base     <= '0;
         cnt      <= '0;
         lin_q    <= 1'b0;
         acc_addr <= '0;
         acc_rd   <= 1'b0;
         acc_wr   <= 1'b0;
         acc_ds   <= 1'b0;
         acc_mask <= '0;
      end else begin
         active   <= nxt_active;
         base     <= nxt_base;
         cnt      <= nxt_cnt;
         lin_q    <= ord_lin;
         acc_addr <= {nxt_base[ADDR_W-1:BURST_W], beat_low(nxt_base[BURST_W-1:0], nxt_cnt, ord_lin)};
         acc_rd   <= nxt_active && !is_wr;
         acc_wr   <= nxt_active && is_wr;
         acc_ds   <= desel;
         acc_mask <= nxt_active ? mask_c : '0;
      end
   end

   // R5: linear beats step the low bits by one
   a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && strobe_cpu_n && strobe_ctl_n && !adv_n && ord_lin && lin_q)
      |=> acc_addr[BURST_W-1:0] == $past(acc_addr[BURST_W-1:0]) + 2'd1);
   // R6: interleaved beats always flip bit 0
   a_r6_inter_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && strobe_cpu_n && strobe_ctl_n && !adv_n && !ord_lin && !lin_q)
      |=> acc_addr[0] != $past(acc_addr[0]));
   // R4: without advance the same word is accessed again
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active && strobe_cpu_n && strobe_ctl_n && adv_n && ord_lin == lin_q)
      |=> $stable(acc_addr) && (acc_rd || acc_wr));
   // R1: processor strobe while unselected is ignored
   a_r1_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_cpu_n && strobe_ctl_n && !sel && adv_n && active && ord_lin == lin_q)
      |=> $stable(acc_addr) && !acc_ds);
   // R8: write-all leaves no lane unwritten
   a_r8_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_all_n |=> !acc_rd && (!acc_wr || &acc_mask));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    rd_en,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [LANES*LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (wr_mask[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
      if (rd_en) rdata <= mem[addr];
   end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              cs_n,
   input  logic              cs,
   input  logic              cs2_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              wr_all_n,
   input  logic              ord_lin,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drv
);
   if (ADDR_W < BURST_W + 1) begin : g_bad_addr
      $error("ADDR_W must exceed the burst field width");
   end
   if (LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("LANES must be 2 or 4");
   end

   logic              sel;
   logic [ADDR_W-1:0] acc_addr;
   logic              acc_rd, acc_wr, acc_ds;
   logic [LANES-1:0]  acc_mask;
   logic [DATA_W-1:0] wdata_q, rdata;
   logic              rd1, ds1, rd2, tail;
   logic [DATA_W-1:0] dout_q;

   assign sel = !cs_n && cs && !cs2_n;

   sbsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .sel(sel), .ord_lin(ord_lin), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
      .wr_all_n(wr_all_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
      .acc_wr(acc_wr), .acc_ds(acc_ds), .acc_mask(acc_mask)
   );

   always_ff @(posedge clk) wdata_q <= din;

   sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
      .clk(clk), .addr(acc_addr), .rd_en(acc_rd),
      .wr_mask(acc_wr ? acc_mask : '0), .wdata(wdata_q), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd1    <= 1'b0;
         ds1    <= 1'b0;
         rd2    <= 1'b0;
         tail   <= 1'b0;
         dout_q <= '0;
      end else begin
         rd1  <= acc_rd;
         ds1  <= acc_ds;
         rd2  <= rd1;
         tail <= rd2 && ds1;
         if (rd1) dout_q <= rdata;
      end
   end

   assign dout     = dout_q;
   assign dout_drv = !oe_n && (rd2 || tail);

   // R3: a read access reaches the output stage two edges later
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> ##1 rd2);
   // R10: the extra drive cycle keeps the data and lasts one cycle
   a_r10_tail_data: assert property (@(posedge clk) disable iff (!rst_n)
      tail |-> $stable(dout_q));
   a_r10_tail_once: assert property (@(posedge clk) disable iff (!rst_n)
      tail |=> !tail);
   // R7: an access is never both a read and a write
   a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_rd && acc_wr));
endmodule

// File: tb/sbsram_top_tb_top.sv
module sbsram_top_tb_top;
   localparam int AW = 6;
   localparam int LN = 4;
   localparam int DW = LN * 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
   logic cs_n = 1'b0, cs = 1'b1, cs2_n = 1'b0;
   logic bwe_n = 1'b1, wr_all_n = 1'b1, ord_lin = 1'b1, oe_n = 1'b0;
   logic [LN-1:0] lane_we_n = '1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic dout_drv;

   always #10 clk = ~clk;

   sbsram_top #(.ADDR_W(AW), .LANES(LN)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_cpu_n(strobe_cpu_n),
      .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .cs_n(cs_n), .cs(cs),
      .cs2_n(cs2_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .wr_all_n(wr_all_n),
      .ord_lin(ord_lin), .oe_n(oe_n), .din(din), .dout(dout), .dout_drv(dout_drv)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R12";

   logic [DW-1:0] ref_mem [1<<AW];
   logic r_act = 0;
   logic [AW-1:0] r_base = '0;
   logic [1:0] r_cnt = '0;
   logic p_rd [3] = '{0, 0, 0};
   logic p_ds [3] = '{0, 0, 0};
   logic [DW-1:0] p_dat [3];
   logic prev_rd = 0;

   // staged inputs for the next edge
   logic [AW-1:0] s_addr;
   logic s_cpu, s_ctl, s_adv, s_csp, s_bwe, s_wall, s_lin;
   logic [LN-1:0] s_lanes;
   logic [DW-1:0] s_din;

   // burst table: {addr[5:0], ord_lin, use_controller_strobe}
   localparam logic [7:0] BURSTS [8] = '{
      {6'd0, 1'b1, 1'b1}, {6'd5, 1'b1, 1'b0}, {6'd10, 1'b1, 1'b1}, {6'd15, 1'b1, 1'b0},
      {6'd20, 1'b0, 1'b1}, {6'd25, 1'b0, 1'b0}, {6'd30, 1'b0, 1'b1}, {6'd63, 1'b0, 1'b0}
   };

   function automatic logic [DW-1:0] pat(input int i);
      logic [5:0] v = 6'(i);
      return {v, v ^ 6'h2A, v + 6'd7, ~v, 6'(v * 3), v ^ 6'h15};
   endfunction

   task automatic chk(input logic ok, input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic idle_stage();
      s_addr = '0; s_cpu = 1; s_ctl = 1; s_adv = 1; s_csp = 1;
      s_bwe = 1; s_wall = 1; s_lin = ord_lin; s_lanes = '1; s_din = '0;
   endtask

   task automatic step();
      logic exp_drv, sel, start, desel;
      logic [AW-1:0] a;
      logic [LN-1:0] m;
      @(negedge clk);
      exp_drv = (p_rd[2] || (prev_rd && p_ds[2])) && !oe_n;
      chk(dout_drv == exp_drv, {tag, " drive"}, DW'(dout_drv), DW'(exp_drv));
      if (p_rd[2] && !oe_n) chk(dout == p_dat[2], {tag, " data"}, dout, p_dat[2]);
      prev_rd = p_rd[2];
      p_rd[2] = p_rd[1]; p_ds[2] = p_ds[1]; p_dat[2] = p_dat[1];
      p_rd[1] = p_rd[0]; p_ds[1] = p_ds[0]; p_dat[1] = p_dat[0];
      addr = s_addr; strobe_cpu_n = s_cpu; strobe_ctl_n = s_ctl; adv_n = s_adv;
      cs = s_csp; bwe_n = s_bwe; wr_all_n = s_wall; ord_lin = s_lin;
      lane_we_n = s_lanes; din = s_din;
      sel = !cs_n && cs && !cs2_n;
      start = sel && (!s_cpu || !s_ctl);
      desel = !s_ctl && !sel;
      if (desel) r_act = 0;
      else if (start) begin r_act = 1; r_base = s_addr; r_cnt = 0; end
      else if (r_act && !s_adv) r_cnt = r_cnt + 2'd1;
      a = {r_base[AW-1:2], s_lin ? r_base[1:0] + r_cnt : r_base[1:0] ^ r_cnt};
      for (int i = 0; i < LN; i++) m[i] = !s_wall || (!s_bwe && !s_lanes[i]);
      p_ds[0] = desel; p_rd[0] = 0; p_dat[0] = '0;
      if (r_act && m != 0) begin
         for (int i = 0; i < LN; i++) if (m[i]) ref_mem[a][i*9 +: 9] = s_din[i*9 +: 9];
      end else if (r_act) begin
         p_rd[0] = 1; p_dat[0] = ref_mem[a];
      end
      idle_stage();
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle_stage();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12: reset state, then continuation edges with advance do nothing
      chk(dout_drv == 0, "R12 reset drive", DW'(dout_drv), '0);
      tag = "R12";
      for (int i = 0; i < 3; i++) begin s_adv = 0; step(); end

      // R8 + R2: fill every word through the controller strobe with write-all
      tag = "R8";
      for (int i = 0; i < (1 << AW); i++) begin
         s_ctl = 0; s_addr = AW'(i); s_wall = 0; s_din = pat(i); step();
      end
      flush();

      // R5 / R6 / R2 / R3: table of bursts
      for (int b = 0; b < 8; b++) begin
         tag = BURSTS[b][1] ? "R5" : "R6";
         s_addr = BURSTS[b][7:2]; s_lin = BURSTS[b][1];
         if (BURSTS[b][0]) s_ctl = 0; else s_cpu = 0;
         step();
         for (int k = 0; k < 3; k++) begin s_adv = 0; s_lin = BURSTS[b][1]; step(); end
      end
      flush();

      // R4: hold without advance
      tag = "R4";
      s_ctl = 0; s_addr = 6'd33; step();
      step(); step();
      s_adv = 0; step();
      step();
      s_adv = 0; step();
      flush();

      // R7: partial lane write, then byte enables without qualifier
      tag = "R7";
      s_ctl = 0; s_addr = 6'd5; s_bwe = 0; s_lanes = 4'b1010; s_din = {4{9'h1A5}}; step();
      s_ctl = 0; s_addr = 6'd5; step();
      s_ctl = 0; s_addr = 6'd6; s_bwe = 1; s_lanes = 4'b0000; s_din = '1; step();
      s_ctl = 0; s_addr = 6'd6; step();
      flush();

      // R8: write-all with lanes and qualifier inactive
      tag = "R8";
      s_ctl = 0; s_addr = 6'd7; s_wall = 0; s_din = {4{9'h0F3}}; step();
      s_ctl = 0; s_addr = 6'd7; step();
      flush();

      // R9: read right after write of same word
      tag = "R9";
      s_ctl = 0; s_addr = 6'd9; s_bwe = 0; s_lanes = 4'b0000; s_din = {4{9'h155}}; step();
      s_cpu = 0; s_addr = 6'd9; step();
      flush();

      // R1: processor strobe while unselected is ignored mid-burst
      tag = "R1";
      s_ctl = 0; s_addr = 6'd16; step();
      s_adv = 0; step();
      s_cpu = 0; s_csp = 0; s_addr = 6'd40; s_adv = 0; step();
      s_adv = 0; step();
      // R10: deselect through the controller strobe, extra drive cycle
      tag = "R10";
      s_ctl = 0; s_csp = 0; step();
      step(); step(); step(); step();
      // R1: after deselect continuation edges access nothing
      tag = "R1";
      s_adv = 0; step(); step(); step();
      // R10: write after read, no extra drive cycle
      tag = "R10";
      s_ctl = 0; s_addr = 6'd44; step();
      s_bwe = 0; s_lanes = 4'b0111; s_din = {4{9'h0AA}}; step();
      flush();

      // R11: output enable gates the drive flag asynchronously
      tag = "R11";
      s_ctl = 0; s_addr = 6'd50; step();
      step(); step(); step();
      #2 oe_n = 1;
      #1 chk(dout_drv == 0, "R11 oe high", DW'(dout_drv), '0);
      oe_n = 0;
      #1 chk(dout_drv == 1, "R11 oe low", DW'(dout_drv), DW'(1));
      flush();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule